// File: doc/BRIEF.md
# Shared Video RAM Access Arbiter

This block sits between a CPU and a RAM bank that the CPU shares with a video fetch engine. Each scan line is cut into 171 numbered memory access windows. The windows are grouped in threes. The first two windows of a group belong to the video engine and the third belongs to the CPU. The CPU runs from its own free-running clock. When it reaches the last clock cycle of an access to the shared bank, or to the video chip's IO ports, the arbiter freezes the CPU clock. It releases the clock once the current position is early enough in a CPU window, and at that point it asserts the RAM grant.

The CPU clock is built inside the block as a register that flips on every half-cycle strobe from the CPU oscillator. A freeze therefore always lasts a whole number of half-cycles. Accesses to ROM, to the sound/IO chip, to the second RAM bank and to expansion RAM do not go through the shared-bank decode, so they are never held.

The block also holds a small wait-mode register that drives a WAIT generator. Depending on the mode, the generator stretches M1 cycles, every memory cycle, or no cycle at all, by exactly one CPU clock cycle. On a shared-bank cycle the WAIT is only issued after the frozen clock has been released.

Top module: `vram_arbiter`

## Requirements
- R1: During and right after reset, `cpu_clk`, `cpu_wait` and `ram_grant` are 0 and the wait mode is off.
- R2: Windows are numbered 0 to 170. A CPU alignment point is a window whose index modulo 3 equals 2, combined with a video phase of 0 or 1 inside that window.
- R3: `cpu_clk` changes only on a clock edge where `half_tick` is 1. On such an edge it inverts, unless it is being held.
- R4: The clock is held when a tick arrives while all of these are true: a cycle is active (`cyc_mem` or `cyc_io`), `shared_hit` is set, `at_last` is set, and the cycle is not yet aligned. The hold lasts for every tick that falls outside an alignment point. At the first tick on an alignment point, the clock inverts and `ram_grant` rises on the same edge.
- R5: An access with `shared_hit` at 0 never holds the clock.
- R6: An IO cycle (`cyc_io`) with `shared_hit` set is aligned exactly like a shared memory cycle.
- R7: The wait mode encoding is 00 = off, 01 = memory cycles that also have `cyc_m1`, and 10 or 11 = every memory cycle. IO cycles never get WAIT.
- R8: A qualifying cycle gets exactly one WAIT. `cpu_wait` goes high on a tick edge and stays high for exactly two ticks.
- R9: On a cycle with `shared_hit` set, WAIT starts no earlier than the tick after the one that released the clock.
- R10: When both `cyc_mem` and `cyc_io` are low at a clock edge, `ram_grant` drops and the cycle's alignment and WAIT history are cleared.
- R11: A write pulse `wmode_wr` loads `wmode_d`, and the new mode applies from the next clock edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_tick | input | 1 | One-cycle strobe for each CPU oscillator transition |
| win_idx | input | 8 | Current access window within the line (0..170) |
| win_phase | input | 3 | Video cycle count inside the current window |
| cyc_mem | input | 1 | CPU memory cycle in progress |
| cyc_io | input | 1 | CPU IO cycle in progress |
| cyc_m1 | input | 1 | Current cycle is an opcode fetch |
| shared_hit | input | 1 | Address decodes to the shared bank or the video IO ports |
| at_last | input | 1 | Next CPU transition starts the final cycle of the machine cycle |
| wmode_wr | input | 1 | Write strobe for the wait-mode register |
| wmode_d | input | 2 | Wait-mode value to load |
| cpu_clk | output | 1 | Gated CPU clock |
| cpu_wait | output | 1 | CPU WAIT request, active high |
| ram_grant | output | 1 | Shared bank granted to the CPU |

## Verification
All three outputs are registered and can only change on a clock edge. `cpu_clk` and `cpu_wait` move only on edges where a tick is sampled. `ram_grant` rises on the releasing tick edge and falls on the first edge with no active cycle. The bench applies stimulus at the falling edge. A behavioural model is advanced on the rising edge from the same input values the design sees. Every output is then compared at the following falling edge, so each expected value is checked exactly one edge after the stimulus that caused it.

// File: rtl/vra_pkg.sv
package vra_pkg;

  typedef enum logic [1:0] {
    WM_OFF  = 2'b00,
    WM_M1   = 2'b01,
    WM_ALL  = 2'b10,
    WM_ALL2 = 2'b11
  } wmode_e;

  // CPU alignment point: CPU-owned window of a group, early enough in it
  function automatic logic cpu_point(input int unsigned idx, input int unsigned phase,
                                     input int unsigned wins, input int unsigned group,
                                     input int unsigned cpu_pos, input int unsigned span);
    return (idx < wins) && ((idx % group) == cpu_pos) && (phase < span);
  endfunction

  // Does a memory cycle earn a WAIT under this mode
  function automatic logic wait_wanted(input logic [1:0] mode, input logic mem, input logic m1);
    logic r;
    case (mode)
      WM_OFF:  r = 1'b0;
      WM_M1:   r = mem & m1;
      default: r = mem;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/vra_slot_align.sv
module vra_slot_align #(
  parameter int WIN_W   = 8,
  parameter int PH_W    = 3,
  parameter int WINS    = 171,
  parameter int GROUP   = 3,
  parameter int CPU_POS = 2,
  parameter int SPAN    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIN_W-1:0] win_idx,
  input  logic [PH_W-1:0]  win_phase,
  output logic             align_ok
);
  import vra_pkg::*;

  always_comb begin
    align_ok = cpu_point(int'(win_idx), int'(win_phase), WINS, GROUP, CPU_POS, SPAN);
  end

  AST_ALIGN_IN_CPU_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    align_ok |-> (win_phase < PH_W'(SPAN)) && (win_idx < WIN_W'(WINS))); // R2

endmodule

// File: rtl/vra_clk_stretch.sv
module vra_clk_stretch (
  input  logic clk,
  input  logic rst_n,
  input  logic half_tick,
  input  logic cyc_act,
  input  logic need_align,
  input  logic align_ok,
  output logic cpu_clk,
  output logic ram_grant,
  output logic aligned,
  output logic hold_now,
  output logic release_now
);
  logic pending;

  always_comb begin
    pending     = half_tick & need_align & ~aligned;
    hold_now    = pending & ~align_ok;
    release_now = pending & align_ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_clk   <= 1'b0;
      ram_grant <= 1'b0;
      aligned   <= 1'b0;
    end else begin
      if (half_tick && !hold_now) cpu_clk <= ~cpu_clk;
      if (!cyc_act) begin
        aligned   <= 1'b0;
        ram_grant <= 1'b0;
      end else if (release_now) begin
        aligned   <= 1'b1;
        ram_grant <= 1'b1;
      end
    end
  end

  AST_CLK_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !half_tick |=> $stable(cpu_clk)); // R3
  AST_GRANT_ON_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_grant) |-> ($past(align_ok) && $past(half_tick))); // R4
  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    hold_now |=> $stable(cpu_clk)); // R4

endmodule

// File: rtl/vra_wait_gen.sv
module vra_wait_gen #(
  parameter int HALVES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       half_tick,
  input  logic       wmode_wr,
  input  logic [1:0] wmode_d,
  input  logic       cyc_act,
  input  logic       cyc_mem,
  input  logic       cyc_m1,
  input  logic       shared_hit,
  input  logic       aligned,
  output logic       cpu_wait,
  output logic [1:0] mode_q
);
  import vra_pkg::*;
  localparam int CW = $clog2(HALVES + 1);

  logic [CW-1:0] cnt;
  logic          waited;
  logic          start;

  always_comb begin
    start    = half_tick && (cnt == '0) && !waited &&
               wait_wanted(mode_q, cyc_mem, cyc_m1) && (!shared_hit || aligned);
    cpu_wait = (cnt != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= WM_OFF;
      cnt    <= '0;
      waited <= 1'b0;
    end else begin
      if (wmode_wr) mode_q <= wmode_d;
      if (half_tick) begin
        if (cnt != '0) cnt <= cnt - 1'b1;
        else if (start) cnt <= CW'(HALVES);
      end
      if (!cyc_act) waited <= 1'b0;
      else if (start) waited <= 1'b1;
    end
  end

  AST_WAIT_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_wait) |-> ($past(mode_q) != WM_OFF)); // R7
  AST_WAIT_MEM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_wait) |-> $past(cyc_mem)); // R7
  AST_WAIT_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_wait) |=> cpu_wait); // R8
  AST_WAIT_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpu_wait) && $past(shared_hit)) |-> $past(aligned)); // R9

endmodule

// File: rtl/vram_arbiter.sv
module vram_arbiter #(
  parameter int WIN_W   = 8,
  parameter int PH_W    = 3,
  parameter int WINS    = 171,
  parameter int GROUP   = 3,
  parameter int CPU_POS = 2,
  parameter int SPAN    = 2,
  parameter int HALVES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_tick,
  input  logic [WIN_W-1:0] win_idx,
  input  logic [PH_W-1:0]  win_phase,
  input  logic             cyc_mem,
  input  logic             cyc_io,
  input  logic             cyc_m1,
  input  logic             shared_hit,
  input  logic             at_last,
  input  logic             wmode_wr,
  input  logic [1:0]       wmode_d,
  output logic             cpu_clk,
  output logic             cpu_wait,
  output logic             ram_grant
);
  logic       align_ok;
  logic       cyc_act;
  logic       need_align;
  logic       aligned;
  logic       hold_now;
  logic       release_now;
  logic [1:0] mode_q;

  always_comb begin
    cyc_act    = cyc_mem | cyc_io;
    need_align = cyc_act & shared_hit & at_last;
  end

  vra_slot_align #(
    .WIN_W(WIN_W), .PH_W(PH_W), .WINS(WINS), .GROUP(GROUP),
    .CPU_POS(CPU_POS), .SPAN(SPAN)
  ) u_align (
    .clk(clk), .rst_n(rst_n), .win_idx(win_idx), .win_phase(win_phase),
    .align_ok(align_ok)
  );

  vra_clk_stretch u_stretch (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .cyc_act(cyc_act),
    .need_align(need_align), .align_ok(align_ok), .cpu_clk(cpu_clk),
    .ram_grant(ram_grant), .aligned(aligned), .hold_now(hold_now),
    .release_now(release_now)
  );

  vra_wait_gen #(.HALVES(HALVES)) u_wait (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .wmode_wr(wmode_wr),
    .wmode_d(wmode_d), .cyc_act(cyc_act), .cyc_mem(cyc_mem), .cyc_m1(cyc_m1),
    .shared_hit(shared_hit), .aligned(aligned), .cpu_wait(cpu_wait),
    .mode_q(mode_q)
  );

  AST_PLAIN_NEVER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && !shared_hit) |=> (cpu_clk != $past(cpu_clk))); // R5
  AST_GRANT_DROPS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_act |=> !ram_grant); // R10
  AST_HOLD_NEEDS_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_now |-> (shared_hit && at_last && !align_ok)); // R6
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wmode_wr |=> (mode_q == $past(wmode_d))); // R11
  AST_RELEASE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    release_now |=> aligned); // R4

endmodule

// File: tb/tb_vram_arbiter.sv
module tb_vram_arbiter;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       half_tick = 0;
  logic [7:0] win_idx = 0;
  logic [2:0] win_phase = 0;
  logic       cyc_mem = 0, cyc_io = 0, cyc_m1 = 0, shared_hit = 0, at_last = 0;
  logic       wmode_wr = 0;
  logic [1:0] wmode_d = 0;
  logic       cpu_clk, cpu_wait, ram_grant;

  vram_arbiter dut (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .win_idx(win_idx),
    .win_phase(win_phase), .cyc_mem(cyc_mem), .cyc_io(cyc_io), .cyc_m1(cyc_m1),
    .shared_hit(shared_hit), .at_last(at_last), .wmode_wr(wmode_wr),
    .wmode_d(wmode_d), .cpu_clk(cpu_clk), .cpu_wait(cpu_wait), .ram_grant(ram_grant)
  );

  always #10 clk = ~clk;

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    gen_en = 0;
  bit    cmp_en = 0;
  bit    done = 0;

  // free-running oscillator and video counters, one window = 6 clk = 1.5 CPU cycles
  int tick_div = 0;
  always @(negedge clk) begin
    if (gen_en) begin
      tick_div  = (tick_div + 1) % 2;
      half_tick = (tick_div == 0);
      if (win_phase == 3'd5) begin
        win_phase = 0;
        win_idx   = (win_idx == 8'd170) ? 8'd0 : win_idx + 8'd1;
      end else begin
        win_phase = win_phase + 3'd1;
      end
    end
  end

  // behavioural reference
  int m_clk, m_grant, m_left, m_aligned, m_waited, m_mode;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_clk = 0; m_grant = 0; m_left = 0; m_aligned = 0; m_waited = 0; m_mode = 0;
    end else begin
      int  nm;
      bit  busy, need, ok, qual;
      nm   = m_mode;
      busy = cyc_mem || cyc_io;
      ok   = (win_idx < 171) && (win_idx % 3 == 2) && (win_phase < 2);
      if (half_tick) begin
        need = busy && shared_hit && at_last && !m_aligned;
        qual = cyc_mem && ((m_mode == 1 && cyc_m1) || m_mode >= 2);
        // wait decision uses alignment state before this tick
        if (m_left > 0) m_left = m_left - 1;
        else if (qual && !m_waited && (!shared_hit || m_aligned)) begin
          m_left = 2; m_waited = 1;
        end
        if (!(need && !ok)) m_clk = 1 - m_clk;
        if (need && ok) begin m_aligned = 1; m_grant = 1; end
      end
      if (!busy) begin m_aligned = 0; m_grant = 0; m_waited = 0; end
      if (wmode_wr) nm = int'(wmode_d);
      m_mode = nm;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk(cur_req, "cpu_clk", int'(cpu_clk), m_clk);
      chk(cur_req, "ram_grant", int'(ram_grant), m_grant);
      chk(cur_req, "cpu_wait", int'(cpu_wait), (m_left != 0) ? 1 : 0);
    end
  end

  task automatic idle(input int n);
    cyc_mem = 0; cyc_io = 0; cyc_m1 = 0; shared_hit = 0; at_last = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic access(input bit mem, input bit io, input bit m1, input bit hit,
                        input int last_after, input int len);
    cyc_mem = mem; cyc_io = io; cyc_m1 = m1; shared_hit = hit; at_last = 0;
    for (int i = 0; i < len; i++) begin
      if (i == last_after) at_last = 1;
      @(negedge clk);
    end
    idle(1);
  endtask

  task automatic set_mode(input logic [1:0] v);
    wmode_d = v; wmode_wr = 1;
    @(negedge clk);
    wmode_wr = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "cpu_clk", int'(cpu_clk), 0);
    chk("R1", "cpu_wait", int'(cpu_wait), 0);
    chk("R1", "ram_grant", int'(ram_grant), 0);
    rst_n = 1; gen_en = 1; cmp_en = 1;
    @(negedge clk);
    chk("R1", "cpu_clk_after", int'(cpu_clk), 0);
    cur_req = "R3"; idle(20);                       // R3 free running toggle
    cur_req = "R5"; access(1, 0, 0, 0, 0, 30);      // R5 non-shared never held
    cur_req = "R4"; access(1, 0, 0, 1, 0, 30);      // R4 shared access held
    cur_req = "R6"; access(0, 1, 0, 1, 2, 30);      // R6 video IO port aligned
    cur_req = "R11"; set_mode(2'b01); idle(2);      // R11 mode load
    cur_req = "R7"; access(1, 0, 1, 0, 0, 20);      // R7 M1 gets WAIT
    access(1, 0, 0, 0, 0, 20);                      // R7 non-M1 none in mode 01
    access(0, 1, 1, 0, 0, 20);                      // R7 IO never
    set_mode(2'b10);
    access(1, 0, 0, 0, 0, 20);                      // R7 all-memory
    set_mode(2'b11);
    cur_req = "R8"; access(1, 0, 0, 0, 0, 24);      // R8 single two-tick WAIT
    cur_req = "R9"; set_mode(2'b10);
    for (int k = 0; k < 6; k++) access(1, 0, 1, 1, 3 + k, 36); // R9 WAIT after release
    cur_req = "R10";
    access(1, 0, 0, 1, 0, 12); access(1, 0, 0, 1, 0, 12); // R10 re-arm
    cur_req = "R2"; set_mode(2'b00);
    for (int k = 0; k < 14; k++) begin              // R2 every start offset
      access(1, 0, 0, 1, 0, 26);
      idle(k % 5);
    end
    cur_req = "R11"; set_mode(2'b00);
    access(1, 0, 1, 0, 0, 20);                      // R11 off stays silent
    idle(10);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule